// File: doc/BRIEF.md
# Twelve-Channel Event Counter Bank with Pair Chaining

This block counts logic pulses on twelve independent inputs, one binary counter per input. Every input first passes through a two-flop synchronizer and a rising-edge detector, so a pulse of any length adds exactly one count. A common inhibit input stops all counting while it is high. Any even channel can be joined to the odd channel above it. The pair then behaves as one counter of twice the width, and the odd half advances only on the carry out of the even half.

Software reaches the block through a small command port. The port takes a strobe, a five-bit function code and a channel subaddress, and answers one cycle later with read data and two response bits. `rsp_x` means the command was accepted and `rsp_q` means it was carried out. The commands cover:
- nondestructive read;
- read with a bank-wide clear after the last channel;
- clear;
- a test increment of every counter;
- enabling, disabling and testing the attention request.

A sticky attention flag is set when the top bit of any counter that is not in a chained pair becomes 1. The `attn` output shows this flag only while the attention enable is set.

Top module: `evt_scaler_bank`

## Requirements
- R1: After reset all counters, the attention flag and the attention enable are 0, and `rsp_data`, `rsp_q`, `rsp_x` and `attn` are 0.
- R2: Each low-to-high transition on `pulse_in[i]` adds exactly one to counter i, however long the input stays high. The count is visible from the third rising clock edge after the input is first sampled high.
- R3: A rising edge that reaches the counter stage while `inhibit` is high is not counted. Raising or lowering `inhibit` never changes a count by itself.
- R4: With `chain_cfg[p]` = 1, counter 2p+1 ignores its own input and advances only when counter 2p wraps from all ones to zero. With `chain_cfg[p]` = 0, both counters of the pair wrap independently.
- R5: The attention flag is set one cycle after bit CNT_W-1 of any unchained counter is 1, ignores chained counters, and stays set until a bank-wide clear. `attn` is the flag ANDed with the enable.
- R6: Function 0 with subaddress 0 to 11 returns that counter in `rsp_data` with `rsp_q`=1 and `rsp_x`=1, and leaves the counter unchanged. Outside a response cycle, `rsp_data`, `rsp_q` and `rsp_x` are 0.
- R7: Function 2 with subaddress 0 to 11 returns the counter with `rsp_q`=1 and `rsp_x`=1. Only for subaddress 11 does it then zero every counter and the attention flag.
- R8: Function 9, a pulse on `clear_all_in` and a pulse on `init_in` each zero every counter and the attention flag. `init_in` also clears the attention enable.
- R9: Function 25 adds one to every unchained counter and to every chained pair taken as one wide value, whatever the inputs and `inhibit` are doing.
- R10: Function 26 sets and function 24 clears the attention enable. Function 8 answers `rsp_q`=1 exactly when the attention flag is set, whatever the enable is.
- R11: `rsp_x`=1 for functions 0 and 2 with subaddress 0 to 11, and for functions 8, 9, 24, 25 and 26 with any subaddress. Every other command answers `rsp_x`=0, `rsp_q`=0 and `rsp_data`=0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_in | input | NUM_CH | Event inputs, one per channel, asynchronous |
| inhibit | input | 1 | Common count gate; high blocks counting |
| chain_cfg | input | NUM_CH/2 | Bit p joins channel 2p+1 above channel 2p |
| clear_all_in | input | 1 | Synchronous bank-wide clear |
| init_in | input | 1 | Synchronous initialize: bank clear and attention disable |
| cmd_strobe | input | 1 | Command valid for one cycle |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | SUB_W | Channel subaddress |
| rsp_data | output | CNT_W | Read data, valid the cycle after the strobe |
| rsp_q | output | 1 | Command carried out / attention test result |
| rsp_x | output | 1 | Command accepted |
| attn | output | 1 | Attention request (flag AND enable) |

## Verification
The hardest situation to reach from the ports is a counter's top bit turning on, and a chained pair carrying across its boundary, because both need half or all of the counter range to be consumed. The bench overrides the counter width to 8 bits and drives long runs of the increment-all command. It does this with every pair chained and then with none chained. This shows that the flag stays clear while the even halves pass half scale, and that the odd halves pick up exactly one carry. A behavioural model tracks each chained pair as a single wide integer and is compared with the responses on every clock.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
  localparam int FUNC_W = 5;

  typedef enum logic [FUNC_W-1:0] {
    FN_READ      = 5'd0,
    FN_READ_CLR  = 5'd2,
    FN_TEST_ATTN = 5'd8,
    FN_CLEAR     = 5'd9,
    FN_ATTN_OFF  = 5'd24,
    FN_INC_ALL   = 5'd25,
    FN_ATTN_ON   = 5'd26
  } scaler_fn_e;
endpackage

// File: rtl/scaler_input_sync.sv
module scaler_input_sync #(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pulse_in,
  output logic [NUM_CH-1:0] rise
);
  logic [NUM_CH-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pulse_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise = sync_q & ~last_q;

  // R2: an edge is reported for a single cycle only
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/scaler_counter_bank.sv
module scaler_counter_bank #(
  parameter int NUM_CH = 12,
  parameter int CNT_W  = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            rise,
  input  logic                         inhibit,
  input  logic                         test_inc,
  input  logic                         clr_all,
  input  logic [NUM_CH/2-1:0]          chain_en,
  output logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
  output logic [NUM_CH-1:0]            chained
);
  localparam int NUM_PAIR = NUM_CH / 2;

  logic [NUM_CH-1:0]            own_inc;
  logic [NUM_CH-1:0]            step;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_d;

  always_comb begin
    if (test_inc) own_inc = '1;
    else          own_inc = rise & ~{NUM_CH{inhibit}};
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam int EV = 2 * p;
    localparam int OD = 2 * p + 1;
    logic even_wrap;

    assign even_wrap   = own_inc[EV] & (&cnt_q[EV]);
    assign chained[EV] = chain_en[p];
    assign chained[OD] = chain_en[p];
    assign step[EV]    = own_inc[EV];
    assign step[OD]    = chain_en[p] ? even_wrap : own_inc[OD];

    // R4: a chained odd half only moves on a wrap of its even half
    assert_chain_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_en[p] && $past(chain_en[p]) && !$past(clr_all) &&
       (cnt_q[OD] != $past(cnt_q[OD])))
      |-> ($past(&cnt_q[EV]) && (cnt_q[EV] == '0)));
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (clr_all)      cnt_d[i] = '0;
      else if (step[i]) cnt_d[i] = cnt_q[i] + CNT_W'(1);
      else              cnt_d[i] = cnt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2: a counter moves by at most one per cycle, or clears
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == $past(cnt_q[i])) || (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)) ||
      (cnt_q[i] == '0));
    // R3: nothing counts while inhibit is high unless the test increment runs
    assert_inhibit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inhibit) && !$past(test_inc) && !$past(clr_all)) |-> $stable(cnt_q[i]));
    // R8: a bank clear leaves every counter at zero
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_all) |-> (cnt_q[i] == '0));
  end
endmodule

// File: rtl/scaler_cmd_port.sv
module scaler_cmd_port
  import scaler_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CNT_W  = 24,
  parameter int SUB_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_strobe,
  input  logic [FUNC_W-1:0]            cmd_func,
  input  logic [SUB_W-1:0]             cmd_sub,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
  input  logic                         flag_q,
  output logic                         test_inc,
  output logic                         cmd_clr,
  output logic                         en_set,
  output logic                         en_clr,
  output logic [CNT_W-1:0]             rsp_data,
  output logic                         rsp_q,
  output logic                         rsp_x
);
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_CH - 1);

  logic             sub_ok, is_rd, is_rdclr, is_ctl;
  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] data_d;
  logic             q_d, x_d;

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cmd_sub == SUB_W'(i)) sel_cnt = cnt_q[i];
    end
  end

  always_comb begin
    sub_ok   = (cmd_sub <= LAST_SUB);
    is_rd    = cmd_strobe && sub_ok && (cmd_func == FN_READ);
    is_rdclr = cmd_strobe && sub_ok && (cmd_func == FN_READ_CLR);
    is_ctl   = 1'b0;
    test_inc = 1'b0;
    cmd_clr  = 1'b0;
    en_set   = 1'b0;
    en_clr   = 1'b0;
    if (cmd_strobe) begin
      case (cmd_func)
        FN_TEST_ATTN: is_ctl = 1'b1;
        FN_CLEAR:     begin is_ctl = 1'b1; cmd_clr  = 1'b1; end
        FN_ATTN_OFF:  begin is_ctl = 1'b1; en_clr   = 1'b1; end
        FN_INC_ALL:   begin is_ctl = 1'b1; test_inc = 1'b1; end
        FN_ATTN_ON:   begin is_ctl = 1'b1; en_set   = 1'b1; end
        default:      is_ctl = 1'b0;
      endcase
    end
    if (is_rdclr && (cmd_sub == LAST_SUB)) cmd_clr = 1'b1;
    data_d = (is_rd || is_rdclr) ? sel_cnt : '0;
    x_d    = is_rd || is_rdclr || is_ctl;
    q_d    = is_rd || is_rdclr ||
             (cmd_strobe && (cmd_func == FN_TEST_ATTN) && flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
      rsp_q    <= 1'b0;
      rsp_x    <= 1'b0;
    end else begin
      rsp_data <= data_d;
      rsp_q    <= q_d;
      rsp_x    <= x_d;
    end
  end

  // R11: an executed command is always an accepted one
  assert_q_needs_x_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |-> rsp_x);
  // R6: the response lines are quiet outside a response cycle
  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_strobe) |-> (rsp_data == '0 && !rsp_q && !rsp_x));
endmodule

// File: rtl/evt_scaler_bank.sv
module evt_scaler_bank
  import scaler_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CNT_W  = 24,
  parameter int SUB_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    pulse_in,
  input  logic                 inhibit,
  input  logic [NUM_CH/2-1:0]  chain_cfg,
  input  logic                 clear_all_in,
  input  logic                 init_in,
  input  logic                 cmd_strobe,
  input  logic [FUNC_W-1:0]    cmd_func,
  input  logic [SUB_W-1:0]     cmd_sub,
  output logic [CNT_W-1:0]     rsp_data,
  output logic                 rsp_q,
  output logic                 rsp_x,
  output logic                 attn
);
  localparam int MSB = CNT_W - 1;

  logic                         rst_meta_q, rst_sync_n;
  logic [NUM_CH-1:0]            rise;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CH-1:0]            chained;
  logic                         test_inc, cmd_clr, en_set, en_clr;
  logic                         clr_all;
  logic                         flag_q, flag_d, en_q, en_d;
  logic [NUM_CH-1:0]            half_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  scaler_input_sync #(.NUM_CH(NUM_CH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pulse_in (pulse_in),
    .rise     (rise)
  );

  scaler_counter_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rise     (rise),
    .inhibit  (inhibit),
    .test_inc (test_inc),
    .clr_all  (clr_all),
    .chain_en (chain_cfg),
    .cnt_q    (cnt_q),
    .chained  (chained)
  );

  scaler_cmd_port #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SUB_W(SUB_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_strobe (cmd_strobe),
    .cmd_func   (cmd_func),
    .cmd_sub    (cmd_sub),
    .cnt_q      (cnt_q),
    .flag_q     (flag_q),
    .test_inc   (test_inc),
    .cmd_clr    (cmd_clr),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .rsp_data   (rsp_data),
    .rsp_q      (rsp_q),
    .rsp_x      (rsp_x)
  );

  assign clr_all = clear_all_in | init_in | cmd_clr;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) half_vec[i] = cnt_q[i][MSB] & ~chained[i];
    if (clr_all) flag_d = 1'b0;
    else         flag_d = flag_q | (|half_vec);
    if (init_in)     en_d = 1'b0;
    else if (en_set) en_d = 1'b1;
    else if (en_clr) en_d = 1'b0;
    else             en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign attn = flag_q & en_q;

  // R5: the flag is sticky until a bank-wide clear
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(flag_q) && !$past(clr_all)) |-> flag_q);
  // R8: initialize leaves the attention output low
  assert_init_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(init_in) |-> !attn);
endmodule

// File: tb/sim_evt_scaler_bank.sv
module sim_evt_scaler_bank;
  localparam int NCH  = 12;
  localparam int BW   = 8;
  localparam int MASK = (1 << BW) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  pulse_in = '0;
  logic            inhibit = 1'b0;
  logic [NCH/2-1:0] chain_cfg = '0;
  logic            clear_all_in = 1'b0;
  logic            init_in = 1'b0;
  logic            cmd_strobe = 1'b0;
  logic [4:0]      cmd_func = '0;
  logic [3:0]      cmd_sub = '0;
  logic [BW-1:0]   rsp_data;
  logic            rsp_q, rsp_x, attn;

  int    checks = 0;
  int    errors = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  evt_scaler_bank #(.NUM_CH(NCH), .CNT_W(BW), .SUB_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .inhibit(inhibit),
    .chain_cfg(chain_cfg), .clear_all_in(clear_all_in), .init_in(init_in),
    .cmd_strobe(cmd_strobe), .cmd_func(cmd_func), .cmd_sub(cmd_sub),
    .rsp_data(rsp_data), .rsp_q(rsp_q), .rsp_x(rsp_x), .attn(attn)
  );

  // reference model
  int m_cnt [NCH];
  bit m_s1 [NCH];
  bit m_s2 [NCH];
  bit m_s3 [NCH];
  bit m_r1, m_r2, m_flag, m_en, m_q, m_x;
  int m_rd;

  always @(posedge clk) begin
    bit active, rd_ok, clr, tst, hs;
    active = m_r2;
    if (!rst_n) begin m_r1 = 0; m_r2 = 0; end
    else begin m_r2 = m_r1; m_r1 = 1; end
    if (!active || !rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = 0; m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0;
      end
      m_flag = 0; m_en = 0; m_rd = 0; m_q = 0; m_x = 0;
    end else begin
      rd_ok = cmd_strobe && (cmd_func == 0 || cmd_func == 2) && cmd_sub < NCH;
      clr = init_in || clear_all_in || (cmd_strobe && cmd_func == 9) ||
            (cmd_strobe && cmd_func == 2 && cmd_sub == NCH - 1);
      tst = cmd_strobe && cmd_func == 25;
      m_rd = rd_ok ? m_cnt[cmd_sub] : 0;
      m_q = rd_ok || (cmd_strobe && cmd_func == 8 && m_flag);
      m_x = rd_ok || (cmd_strobe && (cmd_func == 8 || cmd_func == 9 ||
            cmd_func == 24 || cmd_func == 25 || cmd_func == 26));
      hs = 0;
      for (int i = 0; i < NCH; i++)
        if (m_cnt[i] > MASK / 2 && !chain_cfg[i/2]) hs = 1;
      m_flag = clr ? 0 : (m_flag || hs);
      if (init_in) m_en = 0;
      else if (cmd_strobe && cmd_func == 26) m_en = 1;
      else if (cmd_strobe && cmd_func == 24) m_en = 0;
      for (int p = 0; p < NCH / 2; p++) begin
        int e, o;
        longint wide;
        e = 2 * p; o = 2 * p + 1;
        if (clr) begin
          m_cnt[e] = 0; m_cnt[o] = 0;
        end else if (chain_cfg[p]) begin
          wide = longint'(m_cnt[o]) * (MASK + 1) + m_cnt[e];
          if (tst || (m_s2[e] && !m_s3[e] && !inhibit)) wide = wide + 1;
          wide = wide % ((MASK + 1) * (MASK + 1));
          m_cnt[e] = int'(wide % (MASK + 1));
          m_cnt[o] = int'(wide / (MASK + 1));
        end else begin
          for (int k = e; k <= o; k++)
            if (tst || (m_s2[k] && !m_s3[k] && !inhibit))
              m_cnt[k] = (m_cnt[k] + 1) & MASK;
        end
      end
      for (int i = 0; i < NCH; i++) begin
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pulse_in[i];
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " data"}, rsp_data, m_rd);
      chk({phase, " q"}, rsp_q, m_q);
      chk({phase, " x"}, rsp_x, m_x);
      chk({phase, " attn"}, attn, m_flag && m_en);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cmd(int f, int s);
    @(negedge clk);
    cmd_strobe = 1'b1; cmd_func = 5'(f); cmd_sub = 4'(s);
    @(negedge clk);
    cmd_strobe = 1'b0; cmd_func = '0; cmd_sub = '0;
  endtask

  task automatic rd_chk(string tag, int ch, int exp);
    cmd(0, ch);
    chk(tag, rsp_data, exp);
    chk(tag, rsp_q, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic inc_n(int n);
    for (int i = 0; i < n; i++) cmd(25, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk("R1 attn", attn, 0);
    chk("R1 q", rsp_q, 0);
    rd_chk("R1 read ch0", 0, 0);

    // R2: long pulse counts once, short pulses each count
    phase = "R2";
    pulse_in[3] = 1'b1; idle(10); pulse_in[3] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      pulse_in[5] = 1'b1; idle(1); pulse_in[5] = 1'b0; idle(2);
    end
    idle(5);
    rd_chk("R2 long pulse ch3", 3, 1);
    rd_chk("R2 short pulses ch5", 5, 3);

    // R3: inhibit blocks and its toggling adds nothing
    phase = "R3";
    inhibit = 1'b1; pulse_in[4] = 1'b1; idle(6); pulse_in[4] = 1'b0; idle(4);
    inhibit = 1'b0;
    for (int k = 0; k < 4; k++) begin inhibit = 1'b1; idle(1); inhibit = 1'b0; idle(1); end
    idle(4);
    rd_chk("R3 inhibited ch4", 4, 0);

    // R9: increment-all
    phase = "R9";
    inhibit = 1'b1;
    cmd(25, 0);
    chk("R9 x", rsp_x, 1);
    chk("R9 q", rsp_q, 0);
    inhibit = 1'b0;
    rd_chk("R9 ch0", 0, 1);
    rd_chk("R9 ch3", 3, 2);

    // R6: read leaves the value intact
    phase = "R6";
    rd_chk("R6 first read ch5", 5, 4);
    chk("R6 x", rsp_x, 1);
    rd_chk("R6 second read ch5", 5, 4);

    // R5 / R10: reach half scale with attention enabled
    phase = "R5";
    cmd(26, 0);
    inc_n(127);
    idle(2);
    chk("R5 attn after half scale", attn, 1);
    phase = "R10";
    cmd(8, 0);
    chk("R10 test attn enabled", rsp_q, 1);
    cmd(24, 0);
    idle(1);
    chk("R10 attn disabled", attn, 0);
    cmd(8, 0);
    chk("R10 test attn while disabled", rsp_q, 1);

    // R7: read-and-clear clears only on the last channel
    phase = "R7";
    cmd(2, 5);
    chk("R7 rdclr ch5 data", rsp_data, 131);
    rd_chk("R7 ch5 kept", 5, 131);
    cmd(2, 11);
    chk("R7 rdclr ch11 data", rsp_data, 128);
    chk("R7 rdclr ch11 q", rsp_q, 1);
    rd_chk("R7 ch0 cleared", 0, 0);
    cmd(8, 0);
    chk("R7 flag cleared", rsp_q, 0);

    // R4: chained pairs carry, unchained pairs wrap apart
    phase = "R4";
    chain_cfg = '1;
    inc_n(256);
    rd_chk("R4 chained even", 0, 0);
    rd_chk("R4 chained odd carry", 1, 1);
    cmd(8, 0);
    chk("R5 chained pairs raise no flag", rsp_q, 0);
    cmd(9, 0);
    chain_cfg = '0;
    inc_n(256);
    rd_chk("R4 unchained odd wraps", 1, 0);
    cmd(8, 0);
    chk("R5 unchained half scale flag", rsp_q, 1);

    // R8: global clear, function 9, initialize
    phase = "R8";
    clear_all_in = 1'b1; idle(1); clear_all_in = 1'b0;
    cmd(8, 0);
    chk("R8 global clear flag", rsp_q, 0);
    inc_n(3);
    cmd(9, 0);
    chk("R11 clear x", rsp_x, 1);
    rd_chk("R8 fn9 ch7", 7, 0);
    cmd(26, 0);
    inc_n(128);
    idle(2);
    chk("R8 attn before init", attn, 1);
    init_in = 1'b1; idle(1); init_in = 1'b0;
    idle(1);
    chk("R8 attn after init", attn, 0);
    rd_chk("R8 init ch2", 2, 0);
    inc_n(128);
    idle(2);
    chk("R8 init disabled enable", attn, 0);
    cmd(8, 0);
    chk("R10 flag set while disabled", rsp_q, 1);

    // R11: invalid commands
    phase = "R11";
    cmd(0, 12);
    chk("R11 bad sub x", rsp_x, 0);
    chk("R11 bad sub q", rsp_q, 0);
    cmd(2, 15);
    chk("R11 bad rdclr x", rsp_x, 0);
    rd_chk("R11 no clear from bad sub", 0, 128);
    cmd(3, 0);
    chk("R11 bad func x", rsp_x, 0);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule